// File: doc/BRIEF.md
# Host-to-Firmware Command Mailbox

This block is the register window through which a host processor hands commands to a power-management microcontroller and gets the outcome back. The host sees a small 32-bit register space. It holds a doorbell/command register, a status register, a source and a destination pointer, four words of outbound payload and four words of inbound results. The firmware side is a plain signal port. It shows the command that was latched, a one-cycle launch pulse, both pointers and the payload. The firmware returns result words, a completion pulse, an error flag and an 8-bit error code.

The host fills the pointers and the payload, then writes the command word. Writing the command word is the trigger. The controller has two states. In `ST_IDLE`, a command write takes the transition *launch*: the word is latched, busy rises and `fw_req` pulses. In `ST_BUSY`, a `fw_done` pulse takes the transition *complete*: busy falls and the error state is captured. If the command asked for it, an interrupt is also raised. The host then polls status or waits for the interrupt, reads the inbound words, and acknowledges the interrupt with a status write. Timeouts are left to host software.

Top module: `fw_mailbox`

## Requirements
- R1: After reset, every mapped register reads zero, the status word is zero and `host_irq` is low.
- R2: A write to offset 0x00 in `ST_IDLE` latches the command word. The fields are: code in bits [7:0], interrupt request in bit 8, sub-command in bits [15:12] and payload length in bytes in bits [23:16]. Status bit 0 (busy) is set on the next clock edge. `fw_req` is high for exactly one cycle after that edge. Offset 0x00 reads back the latched word.
- R3: A write to offset 0x00 in `ST_BUSY` is ignored. The latched command and the firmware-side fields stay unchanged.
- R4: Offset 0x08 (source pointer) and offset 0x0C (destination pointer) are host read/write registers. Their values appear unchanged on `fw_src_ptr` and `fw_dst_ptr`.
- R5: Outbound words at offsets 0x80, 0x84, 0x88 and 0x8C are host read/write. Word i drives `fw_payload[32*i+31:32*i]`.
- R6: A `fw_done` pulse in `ST_BUSY` clears busy on that clock edge. On the same edge it captures `fw_err` into status bit 1 and `fw_err_code` into status bits [23:16]. The code is stored as zero when `fw_err` is low.
- R7: A `fw_done` pulse in `ST_IDLE` has no effect on status.
- R8: A completion raises status bit 2 and `host_irq` only if the command had bit 8 set. Otherwise both stay low.
- R9: A status write with bit 2 set clears status bit 2 and drops `host_irq`. Written values in status bits 0, 1 and [23:16] have no effect.
- R10: Inbound words at offsets 0x90, 0x94, 0x98 and 0x9C take firmware writes (`fw_res_wr`, word index `fw_res_idx`) only in `ST_BUSY`. Host writes to these words are ignored.
- R11: With `host_byte_rd` high, a read returns byte `host_addr[1:0]` of the addressed word in bits [7:0], with the upper bits zero.
- R12: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_byte_rd | input | 1 | Byte-lane read select |
| host_rdata | output | 32 | Host read data (combinational) |
| host_irq | output | 1 | Completion interrupt to host |
| fw_req | output | 1 | One-cycle launch pulse to firmware |
| fw_cmd | output | 8 | Latched command code |
| fw_sub | output | 4 | Latched sub-command |
| fw_len | output | 8 | Latched payload length in bytes |
| fw_src_ptr | output | 32 | Source pointer |
| fw_dst_ptr | output | 32 | Destination pointer |
| fw_payload | output | 128 | Outbound payload, word 0 in the low bits |
| fw_done | input | 1 | Completion pulse from firmware |
| fw_err | input | 1 | Error flag sampled with fw_done |
| fw_err_code | input | 8 | Error code sampled with fw_done |
| fw_res_wr | input | 1 | Result word write strobe |
| fw_res_idx | input | 2 | Result word index |
| fw_res_data | input | 32 | Result word data |

## Verification
The main transaction is driven with seeded random command codes, sub-commands, lengths, pointers, payloads and result words. The interrupt request bit and the error outcome are also random, so both the interrupt and the no-interrupt completion paths are covered, as well as success and error completions. Alternate transactions issue a second command write while busy. This tells an ignored doorbell apart from one that overwrites the latched fields. Status writes without bit 2 are kept apart from real acknowledges, and firmware result writes in idle are kept apart from writes in busy. Directed cases cover reset contents, unmapped reads and a completion pulse in idle. Byte-lane reads of random lanes test lane selection independently of the word read path.

// File: rtl/fw_mailbox_pkg.sv
package fw_mailbox_pkg;

    localparam int WORD_W = 32;
    localparam int REG_AW = 8;

    // Byte offsets of the host-visible registers
    localparam logic [REG_AW-1:0] OFS_CMD  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h04;
    localparam logic [REG_AW-1:0] OFS_SRC  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_DST  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_OUTB = 8'h80;
    localparam logic [REG_AW-1:0] OFS_INB  = 8'h90;

    // Status word bit positions
    localparam int STAT_BUSY     = 0;
    localparam int STAT_ERR      = 1;
    localparam int STAT_IRQ      = 2;
    localparam int STAT_CODE_LSB = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } mbox_state_t;

    // Command word as written by the host
    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] len;
        logic [3:0] sub;
        logic [2:0] rsvd_lo;
        logic       irq_req;
        logic [7:0] code;
    } cmd_word_t;

endpackage

// File: rtl/fw_mailbox_regs.sv
module fw_mailbox_regs
    import fw_mailbox_pkg::*;
#(
    parameter int BUF_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [REG_AW-1:0]           host_addr,
    input  logic                        host_wr,
    input  logic [WORD_W-1:0]           host_wdata,
    input  logic                        host_byte_rd,
    input  logic                        cmd_accept,
    input  logic [WORD_W-1:0]           status_word,
    input  logic [WORD_W*BUF_WORDS-1:0] res_flat,
    output cmd_word_t                   cmd_q,
    output logic [WORD_W-1:0]           src_q,
    output logic [WORD_W-1:0]           dst_q,
    output logic [WORD_W*BUF_WORDS-1:0] out_flat,
    output logic [WORD_W-1:0]           host_rdata
);

    logic [REG_AW-1:0] word_addr;
    logic [WORD_W-1:0] rd_word;

    assign word_addr = {host_addr[REG_AW-1:2], 2'b00};

    // Command latch: loaded only when the controller accepts a launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_accept) begin
            cmd_q <= cmd_word_t'(host_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (host_wr) begin
            if (word_addr == OFS_SRC) src_q <= host_wdata;
            if (word_addr == OFS_DST) dst_q <= host_wdata;
        end
    end

    // Outbound payload words
    for (genvar gi = 0; gi < BUF_WORDS; gi++) begin : g_outb
        localparam logic [REG_AW-1:0] WADDR = OFS_OUTB + REG_AW'(4 * gi);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_flat[gi*WORD_W +: WORD_W] <= '0;
            end else if (host_wr && word_addr == WADDR) begin
                out_flat[gi*WORD_W +: WORD_W] <= host_wdata;
            end
        end
    end

    // Read-back multiplexer
    always_comb begin
        rd_word = '0;
        if (word_addr == OFS_CMD)  rd_word = cmd_q;
        if (word_addr == OFS_STAT) rd_word = status_word;
        if (word_addr == OFS_SRC)  rd_word = src_q;
        if (word_addr == OFS_DST)  rd_word = dst_q;
        for (int i = 0; i < BUF_WORDS; i++) begin
            if (word_addr == OFS_OUTB + REG_AW'(4 * i)) rd_word = out_flat[i*WORD_W +: WORD_W];
            if (word_addr == OFS_INB  + REG_AW'(4 * i)) rd_word = res_flat[i*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        if (host_byte_rd) begin
            host_rdata = {{(WORD_W-8){1'b0}}, rd_word[{host_addr[1:0], 3'b000} +: 8]};
        end else begin
            host_rdata = rd_word;
        end
    end

endmodule

// File: rtl/fw_mailbox_ctrl.sv
module fw_mailbox_ctrl
    import fw_mailbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       doorbell,
    input  logic       irq_ack,
    input  logic       irq_req,
    input  logic       fw_done,
    input  logic       fw_err,
    input  logic [7:0] fw_err_code,
    output logic       busy,
    output logic       cmd_accept,
    output logic       fw_req,
    output logic       err_q,
    output logic [7:0] code_q,
    output logic       irq_pend
);

    mbox_state_t state_q;
    mbox_state_t state_d;
    logic        done_accept;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and transition outputs
    always_comb begin
        state_d     = state_q;
        cmd_accept  = 1'b0;
        done_accept = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (doorbell) begin
                    state_d    = ST_BUSY;
                    cmd_accept = 1'b1;
                end
            end
            ST_BUSY: begin
                if (fw_done) begin
                    state_d     = ST_IDLE;
                    done_accept = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q == ST_BUSY);

    // Completion capture, launch pulse and interrupt pending
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fw_req   <= 1'b0;
            err_q    <= 1'b0;
            code_q   <= '0;
            irq_pend <= 1'b0;
        end else begin
            fw_req <= cmd_accept;
            if (done_accept) begin
                err_q  <= fw_err;
                code_q <= fw_err ? fw_err_code : 8'h00;
            end
            if (done_accept && irq_req) begin
                irq_pend <= 1'b1;
            end else if (irq_ack) begin
                irq_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fw_mailbox_resbuf.sv
module fw_mailbox_resbuf
    import fw_mailbox_pkg::*;
#(
    parameter int BUF_WORDS = 4,
    parameter int IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        busy,
    input  logic                        fw_res_wr,
    input  logic [IDX_W-1:0]            fw_res_idx,
    input  logic [WORD_W-1:0]           fw_res_data,
    output logic [WORD_W*BUF_WORDS-1:0] res_flat
);

    for (genvar gi = 0; gi < BUF_WORDS; gi++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_flat[gi*WORD_W +: WORD_W] <= '0;
            end else if (busy && fw_res_wr && fw_res_idx == IDX_W'(gi)) begin
                res_flat[gi*WORD_W +: WORD_W] <= fw_res_data;
            end
        end
    end

endmodule

// File: rtl/fw_mailbox.sv
module fw_mailbox
    import fw_mailbox_pkg::*;
#(
    parameter int BUF_WORDS = 4,
    parameter int IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [REG_AW-1:0]           host_addr,
    input  logic                        host_wr,
    input  logic [WORD_W-1:0]           host_wdata,
    input  logic                        host_byte_rd,
    output logic [WORD_W-1:0]           host_rdata,
    output logic                        host_irq,
    output logic                        fw_req,
    output logic [7:0]                  fw_cmd,
    output logic [3:0]                  fw_sub,
    output logic [7:0]                  fw_len,
    output logic [WORD_W-1:0]           fw_src_ptr,
    output logic [WORD_W-1:0]           fw_dst_ptr,
    output logic [WORD_W*BUF_WORDS-1:0] fw_payload,
    input  logic                        fw_done,
    input  logic                        fw_err,
    input  logic [7:0]                  fw_err_code,
    input  logic                        fw_res_wr,
    input  logic [IDX_W-1:0]            fw_res_idx,
    input  logic [WORD_W-1:0]           fw_res_data
);

    cmd_word_t                   cmd_q;
    logic                        busy_w;
    logic                        cmd_accept;
    logic                        err_q;
    logic [7:0]                  code_q;
    logic                        irq_pend;
    logic [WORD_W-1:0]           status_word;
    logic [WORD_W*BUF_WORDS-1:0] res_flat;
    logic                        doorbell;
    logic                        irq_ack;

    assign doorbell = host_wr && (host_addr == OFS_CMD);
    assign irq_ack  = host_wr && (host_addr == OFS_STAT) && host_wdata[STAT_IRQ];

    always_comb begin
        status_word = '0;
        status_word[STAT_BUSY] = busy_w;
        status_word[STAT_ERR]  = err_q;
        status_word[STAT_IRQ]  = irq_pend;
        status_word[STAT_CODE_LSB +: 8] = code_q;
    end

    fw_mailbox_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .doorbell    (doorbell),
        .irq_ack     (irq_ack),
        .irq_req     (cmd_q.irq_req),
        .fw_done     (fw_done),
        .fw_err      (fw_err),
        .fw_err_code (fw_err_code),
        .busy        (busy_w),
        .cmd_accept  (cmd_accept),
        .fw_req      (fw_req),
        .err_q       (err_q),
        .code_q      (code_q),
        .irq_pend    (irq_pend)
    );

    fw_mailbox_regs #(.BUF_WORDS(BUF_WORDS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_addr    (host_addr),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_byte_rd (host_byte_rd),
        .cmd_accept   (cmd_accept),
        .status_word  (status_word),
        .res_flat     (res_flat),
        .cmd_q        (cmd_q),
        .src_q        (fw_src_ptr),
        .dst_q        (fw_dst_ptr),
        .out_flat     (fw_payload),
        .host_rdata   (host_rdata)
    );

    fw_mailbox_resbuf #(.BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_resbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy_w),
        .fw_res_wr   (fw_res_wr),
        .fw_res_idx  (fw_res_idx),
        .fw_res_data (fw_res_data),
        .res_flat    (res_flat)
    );

    assign host_irq = irq_pend;
    assign fw_cmd   = cmd_q.code;
    assign fw_sub   = cmd_q.sub;
    assign fw_len   = cmd_q.len;

endmodule

// File: rtl/fw_mailbox_chk.sv
module fw_mailbox_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  host_addr,
    input logic        host_wr,
    input logic [31:0] host_wdata,
    input logic        fw_done,
    input logic        fw_req,
    input logic        host_irq,
    input logic        busy,
    input logic [7:0]  fw_cmd
);

    // R2
    launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_req |-> (busy && $past(host_wr && host_addr == 8'h00 && !busy)));

    // R2
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_req |=> !fw_req);

    // R3
    busy_doorbell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fw_done && host_wr && host_addr == 8'h00) |=> (busy && $stable(fw_cmd)));

    // R6
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fw_done) |=> !busy);

    // R7
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fw_done && !(host_wr && host_addr == 8'h00)) |=> !busy);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> $past(busy && fw_done));

    // R9
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h04 && host_wdata[2] && !(busy && fw_done)) |=> !host_irq);

endmodule

bind fw_mailbox fw_mailbox_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .fw_done    (fw_done),
    .fw_req     (fw_req),
    .host_irq   (host_irq),
    .busy       (busy_w),
    .fw_cmd     (fw_cmd)
);

// File: tb/fw_mailbox_tb_top.sv
`timescale 1ns/1ps
module fw_mailbox_tb_top;

    localparam int NW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   host_addr = '0;
    logic         host_wr = 1'b0;
    logic [31:0]  host_wdata = '0;
    logic         host_byte_rd = 1'b0;
    logic [31:0]  host_rdata;
    logic         host_irq;
    logic         fw_req;
    logic [7:0]   fw_cmd;
    logic [3:0]   fw_sub;
    logic [7:0]   fw_len;
    logic [31:0]  fw_src_ptr;
    logic [31:0]  fw_dst_ptr;
    logic [127:0] fw_payload;
    logic         fw_done = 1'b0;
    logic         fw_err = 1'b0;
    logic [7:0]   fw_err_code = '0;
    logic         fw_res_wr = 1'b0;
    logic [1:0]   fw_res_idx = '0;
    logic [31:0]  fw_res_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model
    logic        m_err = 1'b0;
    logic [7:0]  m_code = '0;
    logic        m_irq = 1'b0;
    logic [31:0] m_res [NW];

    always #2.5 clk = ~clk;

    fw_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_byte_rd(host_byte_rd), .host_rdata(host_rdata),
        .host_irq(host_irq), .fw_req(fw_req), .fw_cmd(fw_cmd), .fw_sub(fw_sub),
        .fw_len(fw_len), .fw_src_ptr(fw_src_ptr), .fw_dst_ptr(fw_dst_ptr),
        .fw_payload(fw_payload), .fw_done(fw_done), .fw_err(fw_err),
        .fw_err_code(fw_err_code), .fw_res_wr(fw_res_wr), .fw_res_idx(fw_res_idx),
        .fw_res_data(fw_res_data)
    );

    function automatic logic [31:0] f_status(logic b, logic e, logic [7:0] c, logic i);
        return {8'h00, c, 13'h0000, i, e, b};
    endfunction

    function automatic logic [31:0] f_cmd(logic [7:0] code, logic irq, logic [3:0] sub, logic [7:0] len);
        return {8'h00, len, sub, 3'b000, irq, code};
    endfunction

    function automatic logic [31:0] f_byte(logic [31:0] w, logic [1:0] lane);
        return {24'h000000, w[lane*8 +: 8]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input bit byte_mode, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_byte_rd = byte_mode;
        #1;
        d = host_rdata;
        host_byte_rd = 1'b0;
    endtask

    task automatic fw_result(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        fw_res_wr = 1'b1; fw_res_idx = idx; fw_res_data = d;
        @(negedge clk);
        fw_res_wr = 1'b0;
    endtask

    task automatic fw_complete(input logic e, input logic [7:0] c);
        @(negedge clk);
        fw_done = 1'b1; fw_err = e; fw_err_code = c;
        @(negedge clk);
        fw_done = 1'b0; fw_err = 1'b0; fw_err_code = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] src, dst, word;
        logic [31:0] outw [NW];
        logic [7:0]  code;
        logic        irq, e;
        logic [3:0]  sub;
        logic [7:0]  len, ec;
        logic [1:0]  lane;
        void'($urandom(32'd20240611));
        for (int k = 0; k < NW; k++) m_res[k] = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        host_read(8'h04, 1'b0, rd); check("R1 status", rd, 32'h0);
        check("R1 irq", {31'h0, host_irq}, 32'h0);
        host_read(8'h00, 1'b0, rd); check("R1 cmd", rd, 32'h0);
        host_read(8'h08, 1'b0, rd); check("R1 src", rd, 32'h0);
        host_read(8'h8C, 1'b0, rd); check("R1 outb", rd, 32'h0);
        host_read(8'h94, 1'b0, rd); check("R1 inb", rd, 32'h0);

        // R12 unmapped offsets
        host_write(8'h40, 32'hDEADBEEF);
        host_read(8'h10, 1'b0, rd); check("R12 0x10", rd, 32'h0);
        host_read(8'h40, 1'b0, rd); check("R12 0x40", rd, 32'h0);
        host_read(8'hA0, 1'b0, rd); check("R12 0xA0", rd, 32'h0);
        host_read(8'hFC, 1'b0, rd); check("R12 0xFC", rd, 32'h0);

        // R10 host write and idle firmware write to inbound are dropped
        host_write(8'h90, 32'h12345678);
        host_read(8'h90, 1'b0, rd); check("R10 host write inb", rd, 32'h0);
        fw_result(2'd1, 32'hCAFEF00D);
        host_read(8'h94, 1'b0, rd); check("R10 idle fw write", rd, 32'h0);

        // R7 completion pulse in idle
        fw_complete(1'b1, 8'h05);
        host_read(8'h04, 1'b0, rd); check("R7 idle done", rd, 32'h0);

        for (int it = 0; it < 40; it++) begin
            src = $urandom; dst = $urandom;
            host_write(8'h08, src);
            host_write(8'h0C, dst);
            check("R4 src port", fw_src_ptr, src);
            check("R4 dst port", fw_dst_ptr, dst);
            host_read(8'h08, 1'b0, rd); check("R4 src read", rd, src);
            host_read(8'h0C, 1'b0, rd); check("R4 dst read", rd, dst);

            for (int k = 0; k < NW; k++) begin
                outw[k] = $urandom;
                host_write(8'h80 + 8'(4 * k), outw[k]);
            end
            for (int k = 0; k < NW; k++) begin
                check("R5 payload port", fw_payload[k*32 +: 32], outw[k]);
                host_read(8'h80 + 8'(4 * k), 1'b0, rd); check("R5 outb read", rd, outw[k]);
            end

            code = 8'($urandom); irq = 1'($urandom); sub = 4'($urandom);
            len = 8'($urandom_range(16, 0));
            word = f_cmd(code, irq, sub, len);
            host_write(8'h00, word);
            check("R2 launch pulse", {31'h0, fw_req}, 32'h1);
            check("R2 fields", {4'h0, sub, len, code, 8'h00}, {4'h0, fw_sub, fw_len, fw_cmd, 8'h00});
            host_read(8'h04, 1'b0, rd); check("R2 busy", rd, f_status(1'b1, m_err, m_code, 1'b0));
            check("R2 pulse ends", {31'h0, fw_req}, 32'h0);
            host_read(8'h00, 1'b0, rd); check("R2 cmd read", rd, word);

            if (it % 2 == 1) begin
                host_write(8'h00, ~word);
                check("R3 no relaunch", {31'h0, fw_req}, 32'h0);
                check("R3 cmd port", {24'h0, fw_cmd}, {24'h0, code});
                host_read(8'h00, 1'b0, rd); check("R3 cmd read", rd, word);
            end

            for (int k = 0; k < NW; k++) begin
                m_res[k] = $urandom;
                fw_result(2'(k), m_res[k]);
            end
            host_write(8'h90 + 8'(4 * (it % NW)), $urandom);

            e = ($urandom_range(2, 0) == 0);
            ec = 8'($urandom_range(7, 1));
            fw_complete(e, ec);
            m_err = e; m_code = e ? ec : 8'h00; m_irq = irq;
            host_read(8'h04, 1'b0, rd); check("R6 status", rd, f_status(1'b0, m_err, m_code, m_irq));
            check("R8 irq line", {31'h0, host_irq}, {31'h0, m_irq});

            host_write(8'h04, 32'h00FF0003);
            host_read(8'h04, 1'b0, rd); check("R9 no-bit2 write", rd, f_status(1'b0, m_err, m_code, m_irq));

            for (int k = 0; k < NW; k++) begin
                host_read(8'h90 + 8'(4 * k), 1'b0, rd); check("R10 inb read", rd, m_res[k]);
            end
            lane = 2'($urandom);
            host_read(8'h90 + 8'(4 * (it % NW)) + 8'(lane), 1'b1, rd);
            check("R11 inb byte", rd, f_byte(m_res[it % NW], lane));
            host_read(8'h80 + 8'(lane), 1'b1, rd);
            check("R11 outb byte", rd, f_byte(outw[0], lane));

            // idle firmware result write must not land
            fw_result(2'd0, ~m_res[0]);
            host_read(8'h90, 1'b0, rd); check("R10 idle write", rd, m_res[0]);

            host_write(8'h04, 32'h0000_0004);
            m_irq = 1'b0;
            check("R9 irq drop", {31'h0, host_irq}, 32'h0);
            host_read(8'h04, 1'b0, rd); check("R9 ack status", rd, f_status(1'b0, m_err, m_code, 1'b0));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule